// File: doc/BRIEF.md
# Serial Channel Data Register with Transfer-Clock Divider

This block is the data register of one serial channel. It is 16 bits wide and serves two purposes. The low field is the parallel buffer that a shift register fills on reception and reads on transmission. A parameter sets this field to 8 or 9 bits. The top 7 bits hold a divide ratio. When the channel uses its internal clock, that ratio turns the operation clock into the transfer clock.

A channel-enable input controls access to the register. While the channel is stopped, a bus write sets every field and a bus read returns every field. While the channel runs, the divisor is frozen, it reads back as zero, and bus writes reach only the buffer. A clock-select input chooses the transfer clock. The first choice is the internal divider, which runs only while the channel is enabled. The second is an external serial clock, used in slave operation. That clock passes through a two-flop synchroniser and edge detection. In both cases the block gives the shift register a transfer-clock level and one-cycle rising-edge and falling-edge pulses.

Top module: `serial_buf_divider`

## Requirements
- R1: After reset the bus read value is 0000h, the transmit data is 0, and the transfer-clock level and both pulses are 0.
- R2: With channel enable at 0, a bus write stores bits 15..9 as the divisor and the low buffer bits as data. A read then returns the divisor in bits 15..9 and the buffer in the low bits.
- R3: With channel enable at 1, a bus write updates only the buffer and leaves the divisor unchanged. The old divisor is visible again once the channel is disabled.
- R4: With channel enable at 1, a bus read returns 0 in bits 15..9.
- R5: A store strobe loads the shift-register word into the buffer on the next clock edge. The transmit-data output always shows the current buffer.
- R6: If a store strobe and a bus write occur in the same cycle, the buffer takes the shift-register word. Any divisor write in that cycle still follows R2 and R3.
- R7: With clock-select at 0 and channel enable at 1, the transfer-clock level has a period of 2*(d+1) cycles and stays high for d+1 of them, where d is the divisor. A rising pulse marks each low-to-high step of the level and a falling pulse marks each high-to-low step. Each pulse lasts one cycle.
- R8: While channel enable is 0, the divider is held at zero, so the level and both pulses are 0. After enable rises, the first level step and rising pulse come d+1 cycles after the first clock edge that sees the enable.
- R9: With clock-select at 1 and channel enable at 1, each rising or falling edge of the external serial clock produces exactly one rising or falling pulse. The pulse is seen two clock edges after the input changes, and the divisor has no effect.
- R10: In the 8-bit configuration, bit 8 cannot be written and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable; locks and hides the divisor when 1 |
| extClkSel | input | 1 | 0: internal divided clock, 1: external serial clock |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 16 | Bus write data |
| busRdData | output | 16 | Bus read data |
| rxStore | input | 1 | Store strobe from the shift register |
| rxData | input | DATA_BITS | Received parallel word |
| txData | output | DATA_BITS | Buffer contents handed to the shift register |
| sclkIn | input | 1 | External serial clock (asynchronous) |
| xferClk | output | 1 | Transfer-clock level |
| xferRise | output | 1 | One-cycle pulse on a rising transfer-clock step |
| xferFall | output | 1 | One-cycle pulse on a falling transfer-clock step |

## Verification
The bench sweeps all 128 divisor values and compares the level and both pulses against an arithmetic model, cycle by cycle, from the edge where the enable is first seen. A divider that is off by one, or that does not restart when the channel is disabled, shifts every expected step. Bus writes made while the channel runs are followed by a read after the channel is disabled. A design that lets the divisor leak through would show a changed divisor there, and with the channel running it would show nonzero upper read bits. Separate checks cover a store strobe colliding with a bus write, bit 8 in an 8-bit instance, and the exact two-edge latency and edge count of the synchronised external clock.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef struct packed {
    logic wrBuf;   // bus write reaches the buffer field
    logic wrDiv;   // bus write reaches the divisor field
    logic ldRx;    // shift-register word goes into the buffer
  } ctlStrobes_t;
endpackage

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
#(
  parameter int DIV_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanEn,
  input  logic                extClkSel,
  input  logic                busWrEn,
  input  logic                rxStore,
  input  logic                sclkIn,
  input  logic [DIV_BITS-1:0] divVal,
  output ctlStrobes_t         strb,
  output logic                xferClk,
  output logic                xferRise,
  output logic                xferFall
);
  localparam logic [DIV_BITS-1:0] ONE = {{(DIV_BITS-1){1'b0}}, 1'b1};

  logic [DIV_BITS-1:0] cnt;
  logic intLvl, intRise, intFall;
  logic syncA, syncB, syncPrev;
  logic extRise, extFall;

  // Access strobes: the store strobe has priority over the bus for the buffer
  always_comb begin
    strb.wrBuf = busWrEn & ~rxStore;
    strb.wrDiv = busWrEn & ~chanEn;
    strb.ldRx  = rxStore;
  end

  // Internal divider, held at zero unless enabled on the internal clock
  always_ff @(posedge clk) begin
    if (!rstN || !chanEn || extClkSel) begin
      cnt     <= '0;
      intLvl  <= 1'b0;
      intRise <= 1'b0;
      intFall <= 1'b0;
    end else begin
      intRise <= 1'b0;
      intFall <= 1'b0;
      if (cnt == divVal) begin
        cnt     <= '0;
        intLvl  <= ~intLvl;
        intRise <= ~intLvl;
        intFall <= intLvl;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  // External clock: two-flop synchroniser plus one delay stage for edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= sclkIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign extRise = chanEn & syncB & ~syncPrev;
  assign extFall = chanEn & ~syncB & syncPrev;

  assign xferClk  = extClkSel ? (chanEn & syncB) : intLvl;
  assign xferRise = extClkSel ? extRise : intRise;
  assign xferFall = extClkSel ? extFall : intFall;

  // R7: the counter never passes the divisor
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= divVal);
  // R7: rise and fall pulses never coincide
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(xferRise && xferFall));
  // R8: a disabled channel leaves the divider idle on the next cycle
  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (cnt == '0) && !intLvl && !intRise);
  // R9: an external edge pulse follows a change of the first sync stage
  p_ext_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (extClkSel && chanEn && xferRise) |-> $past(syncA));
endmodule

// File: rtl/sbd_data.sv
module sbd_data
  import sbd_pkg::*;
#(
  parameter int DATA_BITS = 9,
  parameter int DIV_BITS  = 7,
  parameter int REG_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chanEn,
  input  ctlStrobes_t          strb,
  input  logic [REG_BITS-1:0]  busWrData,
  input  logic [DATA_BITS-1:0] rxData,
  output logic [REG_BITS-1:0]  busRdData,
  output logic [DATA_BITS-1:0] txData,
  output logic [DIV_BITS-1:0]  divVal
);
  localparam int LOW_SPAN = REG_BITS - DIV_BITS;
  localparam int PAD      = LOW_SPAN - DATA_BITS;

  logic [DATA_BITS-1:0] bufReg;
  logic [DIV_BITS-1:0]  divReg;
  logic [DIV_BITS-1:0]  divView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg <= '0;
      divReg <= '0;
    end else begin
      if (strb.wrDiv) divReg <= busWrData[REG_BITS-1:LOW_SPAN];
      if (strb.ldRx)       bufReg <= rxData;
      else if (strb.wrBuf) bufReg <= busWrData[DATA_BITS-1:0];
    end
  end

  assign divView = chanEn ? '0 : divReg;

  generate
    if (PAD > 0) begin : g_padded
      assign busRdData = {divView, {PAD{1'b0}}, bufReg};
    end else begin : g_full
      assign busRdData = {divView, bufReg};
    end
  endgenerate

  assign txData = bufReg;
  assign divVal = divReg;

  // R3: divisor frozen while the channel runs
  p_div_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    chanEn |=> $stable(divReg));
  // R6: a store strobe always lands in the buffer
  p_store_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldRx |=> bufReg == $past(rxData));
endmodule

// File: rtl/serial_buf_divider.sv
module serial_buf_divider
  import sbd_pkg::*;
#(
  parameter int DATA_BITS = 9,
  parameter int DIV_BITS  = 7,
  parameter int REG_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chanEn,
  input  logic                 extClkSel,
  input  logic                 busWrEn,
  input  logic [REG_BITS-1:0]  busWrData,
  output logic [REG_BITS-1:0]  busRdData,
  input  logic                 rxStore,
  input  logic [DATA_BITS-1:0] rxData,
  output logic [DATA_BITS-1:0] txData,
  input  logic                 sclkIn,
  output logic                 xferClk,
  output logic                 xferRise,
  output logic                 xferFall
);
  ctlStrobes_t         strb;
  logic [DIV_BITS-1:0] divVal;

  sbd_ctrl #(.DIV_BITS(DIV_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .extClkSel(extClkSel),
    .busWrEn(busWrEn), .rxStore(rxStore), .sclkIn(sclkIn), .divVal(divVal),
    .strb(strb), .xferClk(xferClk), .xferRise(xferRise), .xferFall(xferFall)
  );

  sbd_data #(.DATA_BITS(DATA_BITS), .DIV_BITS(DIV_BITS), .REG_BITS(REG_BITS)) u_data (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .strb(strb),
    .busWrData(busWrData), .rxData(rxData), .busRdData(busRdData),
    .txData(txData), .divVal(divVal)
  );
endmodule

// File: tb/tb_serial_buf_divider.sv
module tb_serial_buf_divider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanEn = 1'b0, extClkSel = 1'b0, busWrEn = 1'b0, rxStore = 1'b0, sclkIn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [8:0]  rxData = '0;
  logic [15:0] rd9, rd8;
  logic [8:0]  tx9;
  logic [7:0]  tx8;
  logic clk9, rise9, fall9, clk8, rise8, fall8;

  int errors = 0;
  int checks = 0;
  logic [6:0] mDiv = '0;
  logic [8:0] mBuf9 = '0;
  logic [7:0] mBuf8 = '0;

  always #2 clk = ~clk;

  serial_buf_divider #(.DATA_BITS(9)) dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .extClkSel(extClkSel),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(rd9),
    .rxStore(rxStore), .rxData(rxData), .txData(tx9), .sclkIn(sclkIn),
    .xferClk(clk9), .xferRise(rise9), .xferFall(fall9));

  serial_buf_divider #(.DATA_BITS(8)) dut8 (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .extClkSel(extClkSel),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(rd8),
    .rxStore(rxStore), .rxData(rxData[7:0]), .txData(tx8), .sclkIn(sclkIn),
    .xferClk(clk8), .xferRise(rise8), .xferFall(fall8));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a bus write (optionally with a colliding store) and update the model
  task automatic busWrite(input logic [15:0] v, input logic withRx, input logic [8:0] rv);
    @(negedge clk);
    busWrEn = 1'b1; busWrData = v; rxStore = withRx; rxData = rv;
    @(negedge clk);
    busWrEn = 1'b0; rxStore = 1'b0;
    if (!chanEn) mDiv = v[15:9];
    if (withRx) begin mBuf9 = rv; mBuf8 = rv[7:0]; end
    else begin mBuf9 = v[8:0]; mBuf8 = v[7:0]; end
  endtask

  task automatic checkRead(input string req);
    chk(req, {16'h0, rd9}, {16'h0, chanEn ? 7'd0 : mDiv, mBuf9});
    chk({req, " R10"}, {16'h0, rd8}, {16'h0, chanEn ? 7'd0 : mDiv, 1'b0, mBuf8});
    chk({req, " R5 tx"}, {23'h0, tx9}, {23'h0, mBuf9});
  endtask

  // R7/R8: run the internal divider from a cold start and compare every cycle
  task automatic runDiv(input int d);
    int bad = 0;
    chanEn = 1'b0; extClkSel = 1'b0;
    busWrite({d[6:0], 9'h0A5}, 1'b0, 9'h0);
    @(negedge clk);
    chanEn = 1'b1;
    for (int i = 1; i <= 4 * (d + 1); i++) begin
      int q;
      logic eLvl, eRise, eFall;
      @(negedge clk);
      q = i / (d + 1);
      eLvl = q[0];
      eRise = (i % (d + 1) == 0) && q[0];
      eFall = (i % (d + 1) == 0) && !q[0];
      if (clk9 !== eLvl || rise9 !== eRise || fall9 !== eFall) bad++;
    end
    chk($sformatf("R7 R8 divider d=%0d mismatching cycles", d), bad, 0);
    chanEn = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 read", {16'h0, rd9}, 32'h0);
    chk("R1 tx", {23'h0, tx9}, 32'h0);
    chk("R1 clock outputs", {29'h0, clk9, rise9, fall9}, 32'h0);

    // R2/R3/R4/R10: write sweeps with the channel stopped, then running
    for (int en = 0; en < 2; en++) begin
      chanEn = en[0];
      for (int i = 0; i < 64; i++) begin
        logic [15:0] v;
        v = 16'(i * 16'h0A37) ^ 16'(i << 10) ^ 16'h0155;
        busWrite(v, 1'b0, 9'h0);
        checkRead(en == 0 ? "R2 stopped write" : "R3 R4 running write");
      end
      chanEn = 1'b0;
      @(negedge clk);
      checkRead("R3 divisor after run");
    end

    // R5: store strobe alone
    @(negedge clk);
    rxStore = 1'b1; rxData = 9'h1C3;
    @(negedge clk);
    rxStore = 1'b0; mBuf9 = 9'h1C3; mBuf8 = 8'hC3;
    checkRead("R5 store");

    // R6: store colliding with bus write, stopped and running
    busWrite(16'hFE00 | 16'h0011, 1'b1, 9'h0EE);
    checkRead("R6 collide stopped");
    chanEn = 1'b1;
    busWrite(16'h5A5A, 1'b1, 9'h133);
    checkRead("R6 collide running");
    chanEn = 1'b0;
    @(negedge clk);
    checkRead("R6 divisor kept");

    // R7/R8: every divisor, each from a cold start
    for (int d = 0; d < 128; d++) runDiv(d);
    runDiv(3);
    repeat (2) @(negedge clk);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (clk9 || rise9 || fall9) seen++;
      end
      chk("R8 quiet while disabled", seen, 0);
    end

    // R9: external clock, divisor nonzero to show it is ignored
    busWrite(16'h0600, 1'b0, 9'h0);
    extClkSel = 1'b1; chanEn = 1'b1;
    repeat (3) @(negedge clk);
    sclkIn = 1'b1;
    @(negedge clk);
    chk("R9 no pulse after one edge", {31'h0, rise9}, 32'h0);
    @(negedge clk);
    chk("R9 rise after two edges", {31'h0, rise9}, 32'h1);
    @(negedge clk);
    chk("R9 rise is one cycle", {31'h0, rise9}, 32'h0);
    sclkIn = 1'b0;
    repeat (4) @(negedge clk);
    begin
      int nR = 0, nF = 0, eR = 0, eF = 0;
      fork
        begin
          for (int k = 0; k < 24; k++) begin
            sclkIn = ~sclkIn;
            if (sclkIn) eR++; else eF++;
            repeat ((k % 4) + 1) @(negedge clk);
          end
          sclkIn = 1'b0;
          if (eF < eR) eF++;
        end
        begin
          for (int c = 0; c < 24 * 4 + 8; c++) begin
            @(negedge clk);
            if (rise9) nR++;
            if (fall9) nF++;
          end
        end
      join
      chk("R9 rise count", nR, eR);
      chk("R9 fall count", nF, eF);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule